// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block sits between a clocked host and an external asynchronous static RAM of 524288 sixteen-bit words. The host hands it one access at a time (a read or a write of a single word, with a per-byte enable mask). The block turns each access into a strobe sequence whose phase lengths are counted in clock cycles. Those lengths come from parameters, each the ceiling of the nanosecond limit divided by the clock period, with a minimum of one.

Every access starts with one parking cycle. In that cycle the new address is on the pins and chip enable, write enable and both byte strobes are high. The address register only loads in the cycle before, while the sequencer is idle and every strobe is also high, so the address never moves under an active strobe. Output enable stays high for the whole of a write. The block drives the shared data bus only during writes, and it keeps that data for one cycle after write enable rises. After each read the bus is left undriven for a turnaround window before the next access can be accepted. Byte lanes the host did not select are never strobed: a write leaves them untouched in memory, and a read returns them as zero.

The request side is a valid/ready stream. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the host holds its request and fields steady until it is taken. Read data comes back as a one-cycle `rd_valid` pulse with no back-pressure: the host must take the word in that cycle.

Top module: `asram_bridge`

## Requirements
- R1: `req_ready` is high only when no access is in progress. After an accepting edge it stays low, and it returns high exactly WP_CYC+3 cycles later for a write and RD_CYC+TA_CYC+3 cycles later for a read. While it is high, every memory strobe is high and the data bus is undriven.
- R2: `mem_addr` changes only between two cycles in both of which chip enable, write enable and both byte strobes are high. During every strobed cycle it equals the address of the accepted request.
- R3: A write is one parking cycle followed by exactly WP_CYC cycles with chip enable and write enable low. Output enable stays high throughout, and write enable is never low unless chip enable is low.
- R4: Mask bit 0 enables the lower lane (data bits 7:0, `mem_bs_n[0]`) and mask bit 1 enables the upper lane (bits 15:8, `mem_bs_n[1]`); 1 means enabled. A lane strobe goes low only during strobe cycles of a request that enables it. A write never changes a lane it does not enable, and a write with mask 00 changes nothing.
- R5: Write data is driven from the parking cycle until one cycle after write enable rises. It is present in every cycle that write enable is low, and never while output enable is low.
- R6: A read is one parking cycle followed by RD_CYC cycles with chip enable and output enable low and write enable high. The bus is sampled at the end of the last of those cycles. `rd_valid` is a single-cycle pulse in the cycle RD_CYC+2 cycles after the accepting edge, and it never occurs for a write.
- R7: In the `rd_valid` cycle, `rd_data` carries the memory word in the lanes the read enabled and zero in the others.
- R8: The block starts driving the bus only after output enable has been high for at least the two preceding cycles. It never drives while the memory drives.
- R9: An asynchronous active-low reset aborts any access at once. During reset `req_ready` is high, all strobes are high, the bus is undriven and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane enables, bit 0 lower lane |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 lower lane |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data returned from memory |
| mem_dq_oe | output | 1 | Bus driver enable for mem_dq_out |

## Verification
Counted from the accepting edge, `rd_valid` is due in cycle RD_CYC+2. `req_ready` returns in cycle WP_CYC+3 after a write and RD_CYC+TA_CYC+3 after a read. The bench drives and samples on falling edges and counts those falling edges from the accepting edge, so it checks the exact cycle of both events rather than just waiting for them. A behavioural memory model runs on the same falling edges. It decodes the strobes to write its array and drive the bus, and on every cycle it checks address parking, the address presented under a strobe, write data presence and bus contention.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_RSTB,
    ST_CAPT,
    ST_WPUL,
    ST_WHOLD,
    ST_TURN
  } seq_state_e;
endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_wr,
  output seq_state_e state,
  output logic       phase_end
);
  localparam int MAXC = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                          : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;

  // end of the timed phase the sequencer is in
  always_comb begin
    case (st_q)
      ST_RSTB: phase_end = (cnt_q == CW'(RD_CYC - 1));
      ST_WPUL: phase_end = (cnt_q == CW'(WP_CYC - 1));
      ST_TURN: phase_end = (cnt_q == CW'(TA_CYC - 1));
      default: phase_end = 1'b1;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_PARK;
      ST_PARK:  st_d = is_wr ? ST_WPUL : ST_RSTB;
      ST_RSTB:  if (phase_end) st_d = ST_CAPT;
      ST_CAPT:  st_d = ST_TURN;
      ST_TURN:  if (phase_end) st_d = ST_IDLE;
      ST_WPUL:  if (phase_end) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_en,
  input  logic                      strobe_on,
  input  logic                      capture,
  input  logic [LANES*LANE_W-1:0]   bus_in,
  output logic [LANES-1:0]          lane_sel_n,
  output logic [LANES*LANE_W-1:0]   rd_word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] byte_q;

    assign lane_sel_n[i] = ~(lane_en[i] & strobe_on);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (capture) byte_q <= lane_en[i] ? bus_in[i*LANE_W +: LANE_W] : '0;
    end

    assign rd_word[i*LANE_W +: LANE_W] = byte_q;
  end
endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_bs_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                mem_dq_oe
);
  localparam int LANES = DATA_W / 8;

  seq_state_e        state;
  logic              phase_end;
  logic              accept;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              strobe_on;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  // request fields load only while idle, when every strobe is parked high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  asram_seq #(
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC),
    .TA_CYC(TA_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .is_wr    (wr_q),
    .state    (state),
    .phase_end(phase_end)
  );

  assign strobe_on = (state == ST_RSTB) || (state == ST_WPUL);

  asram_lanes #(
    .LANES (LANES),
    .LANE_W(8)
  ) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_en   (mask_q),
    .strobe_on (strobe_on),
    .capture   ((state == ST_RSTB) && phase_end),
    .bus_in    (mem_dq_in),
    .lane_sel_n(mem_bs_n),
    .rd_word   (rd_data)
  );

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ~strobe_on;
  assign mem_we_n   = ~(state == ST_WPUL);
  assign mem_oe_n   = ~(state == ST_RSTB);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_q && ((state == ST_PARK) || (state == ST_WPUL) || (state == ST_WHOLD));
  assign rd_valid   = (state == ST_CAPT);
endmodule

// File: rtl/asram_bridge_chk.sv
module asram_bridge_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_bs_n,
  input logic              mem_dq_oe
);
  logic parked;
  assign parked = mem_ce_n & mem_we_n & (&mem_bs_n);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (parked && mem_oe_n && !mem_dq_oe));

  // R2
  addr_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (parked && $past(parked)));

  // R3
  we_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R5
  wdata_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && $past(mem_dq_oe)));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));
endmodule

bind asram_bridge asram_bridge_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_bs_n (mem_bs_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_bridge_tb.sv
module asram_bridge_tb;
  localparam int RD_C = 2;
  localparam int WP_C = 1;
  localparam int TA_C = 1;

  typedef struct packed {
    logic        wr;
    logic [18:0] a;
    logic [15:0] d;
    logic [1:0]  m;
    logic [15:0] e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 19'h00010, 16'h1234, 2'b11, 16'h0000},
    '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 19'h7FFFF, 16'hABCD, 2'b11, 16'h0000},
    '{1'b1, 19'h7FFFF, 16'h5566, 2'b01, 16'h0000},
    '{1'b0, 19'h7FFFF, 16'h0000, 2'b11, 16'hAB66},
    '{1'b1, 19'h7FFFF, 16'h7788, 2'b10, 16'h0000},
    '{1'b0, 19'h7FFFF, 16'h0000, 2'b11, 16'h7766},
    '{1'b0, 19'h7FFFF, 16'h0000, 2'b01, 16'h0066},
    '{1'b0, 19'h7FFFF, 16'h0000, 2'b10, 16'h7700},
    '{1'b1, 19'h40000, 16'h0F0F, 2'b11, 16'h0000},
    '{1'b1, 19'h40000, 16'hFFFF, 2'b00, 16'h0000},
    '{1'b0, 19'h40000, 16'h0000, 2'b11, 16'h0F0F},
    '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1234}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;
  logic        mem_dq_oe;

  int chk_cnt = 0;
  int fail_cnt = 0;
  int mon_err = 0;
  bit done = 1'b0;
  logic [18:0] cur_addr = '0;

  always #2 clk = ~clk;

  asram_bridge #(
    .RD_CYC(RD_C),
    .WP_CYC(WP_C),
    .TA_CYC(TA_C)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // behavioural memory: 128 words, indexed by address bits 18:16 and 3:0
  logic [15:0] marr [128];
  logic [6:0]  midx;
  logic        model_drv;
  logic [15:0] mword;
  logic        parked;

  assign midx   = {mem_addr[18:16], mem_addr[3:0]};
  assign parked = mem_ce_n & mem_we_n & (&mem_bs_n);

  always_comb begin
    model_drv = !mem_ce_n && !mem_oe_n && mem_we_n && !(&mem_bs_n);
    mword     = marr[midx];
    if (model_drv)
      mem_dq_in = {mem_bs_n[1] ? 8'hA5 : mword[15:8], mem_bs_n[0] ? 8'hA5 : mword[7:0]};
    else
      mem_dq_in = 16'h5A5A;
  end

  logic [18:0] prev_addr = '0;
  logic        prev_parked = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_addr != prev_addr && !(parked && prev_parked)) begin
        mon_err++;
        $display("FAIL R2: address moved under strobe, actual=%h expected=%h", mem_addr, prev_addr);
      end
      if (!mem_ce_n && mem_addr != cur_addr) begin
        mon_err++;
        $display("FAIL R2: strobed address actual=%h expected=%h", mem_addr, cur_addr);
      end
      if (model_drv && mem_dq_oe) begin
        mon_err++;
        $display("FAIL R8: bus contention actual=1 expected=0");
      end
      if (!mem_ce_n && !mem_we_n) begin
        if (!mem_dq_oe || !mem_oe_n) begin
          mon_err++;
          $display("FAIL R5: write pulse dq_oe=%0d oe_n=%0d expected 1 1", mem_dq_oe, mem_oe_n);
        end
        if (!mem_bs_n[0]) marr[midx][7:0]  <= mem_dq_out[7:0];
        if (!mem_bs_n[1]) marr[midx][15:8] <= mem_dq_out[15:8];
      end
    end
    prev_addr   <= mem_addr;
    prev_parked <= parked;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
    $finish;
  endtask

  // one request; latency counted in falling edges after the accepting edge
  task automatic run_req(input logic wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] m, input logic [15:0] e);
    int n;
    int rv_at;
    int rv_num;
    logic [15:0] got;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; rv_at = -1; rv_num = 0; got = '0;
    while (!req_ready && n < 60) begin
      if (rd_valid) begin
        rv_num++;
        rv_at = n;
        got   = rd_data;
      end
      @(negedge clk);
      n++;
    end
    if (wr) begin
      check(n == WP_C + 3, "R1 write ready return", n, WP_C + 3);
      check(rv_num == 0, "R6 no rd_valid on write", rv_num, 0);
    end else begin
      check(n == RD_C + TA_C + 3, "R1 read ready return", n, RD_C + TA_C + 3);
      check(rv_num == 1 && rv_at == RD_C + 2, "R6 rd_valid cycle", rv_at, RD_C + 2);
      check(got == e, "R7 R4 read data", got, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready in reset", req_ready, 1);
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n} == 5'b11111, "R9 strobes in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n}, 5'b11111);
    check(mem_dq_oe == 1'b0 && rd_valid == 1'b0, "R9 bus and rd_valid in reset",
          {mem_dq_oe, rd_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 vector walk
    for (int i = 0; i < NV; i++)
      run_req(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].m, VECS[i].e);

    // R9 abort a write during its parking cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00010; req_wdata = 16'hEEEE; req_mask = 2'b11;
    cur_addr  = 19'h00010;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_dq_oe == 1'b1, "R5 write data in parking cycle", mem_dq_oe, 1);
    #1 rst_n = 1'b0;
    #0.5;
    check(req_ready == 1'b1 && mem_we_n == 1'b1 && mem_ce_n == 1'b1 && mem_dq_oe == 1'b0,
          "R9 abort", {req_ready, mem_we_n, mem_ce_n, mem_dq_oe}, 4'b1110);
    @(negedge clk);
    rst_n = 1'b1;
    // aborted write left memory unchanged
    run_req(1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1234);
    // R4 read with no lanes selected returns zero
    run_req(1'b0, 19'h7FFFF, 16'h0000, 2'b00, 16'h0000);

    check(mon_err == 0, "R2 R5 R8 memory model errors", mon_err, 0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk_cnt++;
      fail_cnt++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      report();
    end
  end
endmodule